// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block takes an ARINC 429 return-to-zero line pair that has already been converted to logic levels. A sample tick runs at ten times the bit rate. The block watches the line pair on each tick and recognises each bit from the line that pulses high. It fills a word register in order of arrival and raises a one-clock strobe when a whole word has come in and has been accepted. The word length is either 25 or 32 bits. A word that stops partway through is dropped without any trace. In the 32-bit format the block can also drop words whose routing bits do not match a two-bit code set by the user.

Each accepted word is given out together with a parity status bit. An internal self-test serial pair can be selected in place of the line pair. A host side is expected to capture the word on the strobe.

Top module: `arinc429_word_rx`

## Requirements
- R1: With `selftest_en`=1 the word is taken only from `selftest_pos`/`selftest_neg`, and activity on `line_pos`/`line_neg` has no effect. With `selftest_en`=0 the roles are swapped.
- R2: A bit is recognised on the second of two consecutive sample ticks that see the same single line high, provided the tick before those two saw both lines low. The positive line carries a 1 and the negative line carries a 0. Both lines low, or both lines high, counts as null.
- R3: The first bit of a word is taken only if at least OVERSAMPLE (10) consecutive null ticks came before its first high sample. Marks that do not meet this rule are ignored until such a quiet period has occurred.
- R4: The k-th received bit (k from 1) is stored in `word_data[k-1]`. Bits above the word length read as 0.
- R5: `long_fmt`=1 makes a word 32 bits long and `long_fmt`=0 makes it 25 bits long.
- R6: While a word is partly received, 2*OVERSAMPLE (20) consecutive null ticks abandon it with no strobe. A following well-formed word is then received normally.
- R7: With `sd_check_en`=1 and `long_fmt`=1, a completed word is accepted only if `word_data[8]`==`sd_code[0]` and `word_data[9]`==`sd_code[1]`. A rejected word gives no strobe and leaves the outputs unchanged.
- R8: In the 25-bit format the routing-bit match is never applied, whatever `sd_check_en` is.
- R9: `parity_even` is 1 when the accepted word holds an even number of ones and 0 when it holds an odd number.
- R10: `word_valid` is high for exactly one clock, the clock after the sample tick that confirms the final bit of an accepted word. `word_data` and `parity_even` change only together with that strobe.
- R11: During reset `word_valid`, `word_data` and `parity_even` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-clock strobe at ten times the bit rate |
| line_pos | input | 1 | Line receiver positive leg, logic level |
| line_neg | input | 1 | Line receiver negative leg, logic level |
| selftest_en | input | 1 | 1 selects the self-test pair |
| selftest_pos | input | 1 | Self-test positive leg |
| selftest_neg | input | 1 | Self-test negative leg |
| long_fmt | input | 1 | 1 = 32-bit words, 0 = 25-bit words |
| sd_check_en | input | 1 | Enables the routing-bit match |
| sd_code | input | 2 | Expected routing bits (bit 0 vs word bit 8, bit 1 vs word bit 9) |
| word_valid | output | 1 | Accepted-word strobe |
| word_data | output | 32 | Last accepted word, first bit in bit 0 |
| parity_even | output | 1 | 1 = even count of ones, 0 = odd |

## Verification
The bench targets the gap rules. It sends a word that stops after ten bits, and a design that misses the abort would join those bits onto the next word and strobe the wrong value early. It also starts a word right after the previous one with no quiet lead-in, and a design that skips the quiet check would accept that word. Routing-bit matches and mismatches are sent in both formats, so a design that filters in 25-bit mode or ignores the code gives the wrong strobe count. The self-test case drives a conflicting pattern on the unselected pair, so a wrong input select shows up as a different word.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2
  } sym_t;

  // one sample of the line pair; both legs high is treated as null
  function automatic sym_t classify(input logic pos, input logic neg);
    if (pos && !neg) return SYM_ONE;
    if (neg && !pos) return SYM_ZERO;
    return SYM_NULL;
  endfunction

  function automatic logic even_ones(input logic [WORD_W-1:0] w);
    return ~^w;
  endfunction

  // routing bits pass when the check is off, in short format, or on a match
  function automatic logic sd_pass(input logic chk_en, input logic long_w,
                                   input logic [1:0] code,
                                   input logic [WORD_W-1:0] w);
    if (!(chk_en && long_w)) return 1'b1;
    return (w[8] == code[0]) && (w[9] == code[1]);
  endfunction

  function automatic logic [WORD_W-1:0] place_bit(input logic [WORD_W-1:0] w,
                                                  input logic [IDX_W-1:0] idx,
                                                  input logic b);
    logic [WORD_W-1:0] r;
    r = w;
    r[idx] = b;
    return r;
  endfunction
endpackage

// File: rtl/a429_sym_sampler.sv
module a429_sym_sampler
  import a429_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 10,
  parameter int GAP_BITS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pos,
  input  logic neg,
  output logic bit_evt,
  output logic bit_val,
  output logic lead_ok,
  output logic gap_hit
);
  localparam int GAP_LIMIT = OVERSAMPLE * GAP_BITS;
  localparam int CW        = $clog2(GAP_LIMIT + 1);

  sym_t          cur, prev1, prev2;
  logic [CW-1:0] nul_cnt;
  logic          lead_q;
  logic          mark_start;

  assign cur        = classify(pos, neg);
  assign mark_start = tick && (cur != SYM_NULL) && (prev1 == SYM_NULL);
  assign bit_evt    = tick && (cur != SYM_NULL) && (cur == prev1) && (prev2 == SYM_NULL);
  assign bit_val    = (cur == SYM_ONE);
  assign lead_ok    = lead_q;
  assign gap_hit    = tick && (cur == SYM_NULL) && (nul_cnt == CW'(GAP_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev1   <= SYM_NULL;
      prev2   <= SYM_NULL;
      nul_cnt <= '0;
      lead_q  <= 1'b0;
    end else if (tick) begin
      prev2 <= prev1;
      prev1 <= cur;
      if (cur == SYM_NULL) begin
        if (nul_cnt != CW'(GAP_LIMIT)) nul_cnt <= nul_cnt + 1'b1;
      end else begin
        nul_cnt <= '0;
      end
      if (mark_start) lead_q <= (nul_cnt >= CW'(OVERSAMPLE));
    end
  end

  a_r6_null_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    nul_cnt <= CW'(GAP_LIMIT));
  a_r3_short_quiet_blocks_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_start && nul_cnt < CW'(OVERSAMPLE)) |=> !lead_q);
  a_r2_bit_needs_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur != SYM_NULL && prev1 == SYM_NULL) |-> !bit_evt);
endmodule

// File: rtl/a429_word_builder.sv
module a429_word_builder
  import a429_rx_pkg::*;
#(
  parameter int SHORT_LEN = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_evt,
  input  logic              bit_val,
  input  logic              lead_ok,
  input  logic              gap_hit,
  input  logic              long_fmt,
  output logic              done,
  output logic [WORD_W-1:0] done_word
);
  logic [IDX_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              in_word, take, abort;
  logic [IDX_W-1:0]  last_idx;

  assign in_word   = (bit_cnt != '0);
  assign take      = bit_evt && (in_word || lead_ok);
  assign last_idx  = long_fmt ? IDX_W'(WORD_W - 1) : IDX_W'(SHORT_LEN - 1);
  assign done      = take && (bit_cnt == last_idx);
  assign done_word = place_bit(shreg, bit_cnt, bit_val);
  assign abort     = gap_hit && in_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (abort) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (take) begin
      if (done) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= done_word;
      end
    end
  end

  a_r6_abort_discards: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (bit_cnt == '0) && (shreg == '0));
  a_r3_no_start_without_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt && !in_word && !lead_ok) |=> (bit_cnt == '0));
  a_r5_short_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_fmt && $stable(long_fmt)) |-> (bit_cnt <= IDX_W'(SHORT_LEN - 1)));
endmodule

// File: rtl/arinc429_word_rx.sv
module arinc429_word_rx
  import a429_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 10,
  parameter int GAP_BITS   = 2,
  parameter int SHORT_LEN  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              line_pos,
  input  logic              line_neg,
  input  logic              selftest_en,
  input  logic              selftest_pos,
  input  logic              selftest_neg,
  input  logic              long_fmt,
  input  logic              sd_check_en,
  input  logic [1:0]        sd_code,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              parity_even
);
  logic              sel_pos, sel_neg;
  logic              bit_evt, bit_val, lead_ok, gap_hit;
  logic              done, accept;
  logic [WORD_W-1:0] done_word;

  assign sel_pos = selftest_en ? selftest_pos : line_pos;
  assign sel_neg = selftest_en ? selftest_neg : line_neg;

  a429_sym_sampler #(.OVERSAMPLE(OVERSAMPLE), .GAP_BITS(GAP_BITS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .pos(sel_pos), .neg(sel_neg),
    .bit_evt(bit_evt), .bit_val(bit_val), .lead_ok(lead_ok), .gap_hit(gap_hit)
  );

  a429_word_builder #(.SHORT_LEN(SHORT_LEN)) u_builder (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_val(bit_val),
    .lead_ok(lead_ok), .gap_hit(gap_hit), .long_fmt(long_fmt),
    .done(done), .done_word(done_word)
  );

  assign accept = done && sd_pass(sd_check_en, long_fmt, sd_code, done_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid  <= 1'b0;
      word_data   <= '0;
      parity_even <= 1'b0;
    end else begin
      word_valid <= accept;
      if (accept) begin
        word_data   <= done_word;
        parity_even <= even_ones(done_word);
      end
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(word_data) && $stable(parity_even)));
  a_r7_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(sd_check_en) && $past(long_fmt)) |->
      (word_data[9:8] == $past(sd_code)));
  a_r4_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !$past(long_fmt)) |-> (word_data[WORD_W-1:SHORT_LEN] == '0));
endmodule

// File: tb/tb_arinc429_word_rx.sv
`timescale 1ns/1ps
module tb_arinc429_word_rx;
  localparam int OS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic line_pos = 1'b0, line_neg = 1'b0;
  logic selftest_en = 1'b0, selftest_pos = 1'b0, selftest_neg = 1'b0;
  logic long_fmt = 1'b1, sd_check_en = 1'b0;
  logic [1:0] sd_code = 2'b00;
  logic word_valid;
  logic [31:0] word_data;
  logic parity_even;

  always #2.5 clk = ~clk;

  arinc429_word_rx dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .line_pos(line_pos), .line_neg(line_neg), .selftest_en(selftest_en),
    .selftest_pos(selftest_pos), .selftest_neg(selftest_neg),
    .long_fmt(long_fmt), .sd_check_en(sd_check_en), .sd_code(sd_code),
    .word_valid(word_valid), .word_data(word_data), .parity_even(parity_even)
  );

  int checks = 0, failures = 0, vcount = 0;
  bit done_flag = 0;

  // reference model state
  int pa = 0, pb = 0, nrun = 0, cnt = 0;
  bit lead = 0;
  logic [31:0] mbits = '0;
  logic [31:0] held_word = '0;
  logic held_par = 1'b0;

  task automatic model_tick(input logic hi, input logic lo, output logic v);
    int cur;
    cur = (hi && !lo) ? 1 : ((lo && !hi) ? 2 : 0);
    v = 1'b0;
    if (cur != 0 && pa == 0) lead = (nrun >= OS);
    if (cur != 0 && cur == pa && pb == 0 && (cnt > 0 || lead)) begin
      mbits[cnt] = (cur == 1);
      cnt++;
      if (cnt == (long_fmt ? 32 : 25)) begin
        if (!(sd_check_en && long_fmt) ||
            (mbits[8] == sd_code[0] && mbits[9] == sd_code[1])) begin
          v = 1'b1;
          held_word = mbits;
          held_par = ($countones(mbits) % 2 == 0);
        end
        cnt = 0;
        mbits = '0;
      end
    end
    if (cur == 0) begin
      if (nrun < 2*OS) nrun++;
      if (cnt > 0 && nrun == 2*OS) begin cnt = 0; mbits = '0; end
    end else begin
      nrun = 0;
    end
    pb = pa;
    pa = cur;
  endtask

  task automatic compare(input logic v);
    checks++;
    if (word_valid !== v) begin
      failures++;
      $display("FAIL R10 strobe: actual=%0b expected=%0b at %0t", word_valid, v, $time);
    end
    if (word_valid) vcount++;
    checks++;
    if (word_data !== held_word) begin
      failures++;
      $display("FAIL R4 word_data: actual=%h expected=%h at %0t", word_data, held_word, $time);
    end
    checks++;
    if (parity_even !== held_par) begin
      failures++;
      $display("FAIL R9 parity_even: actual=%0b expected=%0b at %0t", parity_even, held_par, $time);
    end
  endtask

  bit use_self = 0;

  task automatic tick(input logic hi, input logic lo);
    logic v;
    if (use_self) begin
      selftest_pos = hi; selftest_neg = lo; line_pos = lo; line_neg = hi;
    end else begin
      line_pos = hi; line_neg = lo; selftest_pos = lo; selftest_neg = hi;
    end
    model_tick(hi, lo, v);
    sample_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_tick = 1'b0;
    compare(v);
    repeat (3) begin
      @(negedge clk);
      compare(1'b0);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits,
                           input int lead_n, input int tail_n);
    repeat (lead_n) tick(1'b0, 1'b0);
    for (int i = 0; i < nbits; i++) begin
      repeat (OS/2) tick(w[i], !w[i]);
      repeat (OS/2) tick(1'b0, 1'b0);
    end
    repeat (tail_n) tick(1'b0, 1'b0);
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check_eq("R11 reset valid", {31'd0, word_valid}, 32'd0);
    check_eq("R11 reset data", word_data, 32'd0);
    check_eq("R11 reset parity", {31'd0, parity_even}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R9: 32-bit words, odd and even parity
    base = vcount;
    send_word(32'h0000_0001, 32, 12, 40);
    check_eq("R9 odd count", {31'd0, parity_even}, 32'd0);
    send_word(32'h8000_0003, 32, 0, 40);
    check_eq("R9 odd count 3 ones", {31'd0, parity_even}, 32'd0);
    send_word(32'hA5C3_0F96, 32, 0, 40);
    check_eq("R9 even count", {31'd0, parity_even}, 32'd1);
    check_eq("R4 long word", word_data, 32'hA5C3_0F96);
    check_eq("R5 long count", vcount - base, 3);

    // R5 R8: 25-bit with routing check on and a mismatching code
    long_fmt = 1'b0; sd_check_en = 1'b1; sd_code = 2'b11;
    base = vcount;
    send_word(32'hFFAB_CDEF, 25, 0, 40);
    check_eq("R8 short ignores code", vcount - base, 1);
    check_eq("R4 short upper zero", word_data, 32'h01AB_CDEF);

    // R7: routing match accepted, mismatch rejected
    long_fmt = 1'b1; sd_code = 2'b10;
    base = vcount;
    send_word(32'h1234_5200, 32, 0, 40);
    send_word(32'h7777_7100, 32, 0, 40);
    check_eq("R7 match count", vcount - base, 1);
    check_eq("R7 kept data", word_data, 32'h1234_5200);
    sd_check_en = 1'b0;

    // R6: broken word then good word
    base = vcount;
    send_word(32'hFFFF_FFFF, 10, 0, 25);
    send_word(32'h0F0F_3C3C, 32, 0, 40);
    check_eq("R6 one strobe", vcount - base, 1);
    check_eq("R6 data", word_data, 32'h0F0F_3C3C);

    // R3: word with no quiet lead-in is ignored
    base = vcount;
    send_word(32'h1111_2222, 32, 0, 0);
    send_word(32'hDEAD_BEEF, 32, 0, 40);
    check_eq("R3 lead gate count", vcount - base, 1);
    check_eq("R3 data", word_data, 32'h1111_2222);

    // R1 R2: self-test pair selected, line carries inverted decoy
    use_self = 1; selftest_en = 1'b1;
    base = vcount;
    send_word(32'h6B3A_C901, 32, 0, 40);
    check_eq("R1 self-test count", vcount - base, 1);
    check_eq("R1 R2 self-test data", word_data, 32'h6B3A_C901);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule